// File: doc/BRIEF.md
# Prescaled Watchdog Timeout Counter

This block is a watchdog for a system-management device. Software programs a 5-bit timeout field and a one-bit base select. A kick strobe loads the countdown with field + 1, so the timeout covers 1 to 32 base intervals. The base interval is either a short or a long period, each a parameter counted in clock cycles. The countdown steps down once per base interval. When it reaches zero it sets a time-out status flag. That flag stays set until a clear strobe arrives. The counter then rests at zero until the next kick.

An enable input freezes both the countdown and the interval divider. Next to the timer sits the operating-frequency code selector. The external frequency-select pins are captured once, on the first clock after reset, and the captured value is visible on a read-only output. An override input chooses whether the code comes from that captured value or from the software selection bits.

Top module: `prescaled_wdog`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `wd_count` is 0 and `wd_expired` is 0.
- R2: A `kick` pulse loads `wd_count` with `tmo_field` + 1 on the following edge (value 1 to 32) and restarts the interval divider, whatever the state of `enable` or of the count.
- R3: With `base_long` = 0 sampled at the kick, `wd_count` decrements every TICK_SHORT enabled cycles after the kick. With `base_long` = 1 it decrements every TICK_LONG enabled cycles.
- R4: Changes to `tmo_field` or `base_long` after a kick do not alter the running countdown until the next kick.
- R5: On the edge where `wd_count` goes from 1 to 0, `wd_expired` becomes 1. After that, `wd_count` stays at 0 until a kick.
- R6: `wd_expired` stays 1 until a `clr_expired` pulse clears it. When expiry and clear fall on the same edge, the flag is set.
- R7: While `enable` is 0 and no kick is given, `wd_count` and the interval divider hold their values. Counting resumes where it stopped.
- R8: `pins_latched` takes the value of `freq_pins` on the first clock edge after reset and holds it afterwards, regardless of later pin changes.
- R9: `freq_code` equals `sw_freq` when `freq_override` = 1, and equals `pins_latched` when `freq_override` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable for countdown and divider |
| tmo_field | input | 5 | Timeout field, count = value + 1 intervals |
| base_long | input | 1 | Interval select: 0 short, 1 long |
| kick | input | 1 | Reload strobe |
| clr_expired | input | 1 | Clears the time-out flag |
| freq_override | input | 1 | 1 selects software frequency code |
| freq_pins | input | 5 | External frequency-select pins |
| sw_freq | input | 5 | Software frequency selection bits |
| wd_count | output | 6 | Remaining intervals |
| wd_expired | output | 1 | Sticky time-out flag |
| pins_latched | output | 5 | Captured frequency pins |
| freq_code | output | 5 | Selected frequency code |

## Verification
The bench builds the block with TICK_SHORT = 3 and TICK_LONG = 7 instead of real millisecond periods. With these values, a full 32-interval countdown on the long base takes only 224 cycles. Thousands of random cycles can therefore reach many expiries, clears and mid-count reprogrammings. The short and long periods are unequal and coprime, so a wrong base select or an off-by-one in the divider changes the cycle on which the count steps, and the per-cycle comparison reveals it.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   typedef enum logic {
      BASE_SHORT = 1'b0,
      BASE_LONG  = 1'b1
   } base_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
   import wdt_pkg::*;
#(
   parameter int unsigned TICK_SHORT = 150000,
   parameter int unsigned TICK_LONG  = 2500000
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  run,
   input  logic  restart,
   input  base_e base_sel,
   output logic  tick
);
   localparam int unsigned TMAX = max_u(TICK_SHORT, TICK_LONG);
   localparam int unsigned PW   = $clog2(TMAX + 1);

   logic [PW-1:0] pre_cnt;
   logic [PW-1:0] limit_m1;

   always_comb begin
      if (base_sel == BASE_LONG) limit_m1 = PW'(TICK_LONG - 1);
      else                       limit_m1 = PW'(TICK_SHORT - 1);
   end

   assign tick = run && !restart && (pre_cnt == limit_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       pre_cnt <= '0;
      else if (restart) pre_cnt <= '0;
      else if (run)     pre_cnt <= tick ? '0 : pre_cnt + 1'b1;
   end

   // R3
   pre_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pre_cnt <= limit_m1 || $past(restart) == 1'b0);

   // R7
   pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !restart) |=> $stable(pre_cnt));
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown
   import wdt_pkg::*;
#(
   parameter int unsigned FIELD_W = 5,
   localparam int unsigned CW     = FIELD_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic               kick,
   input  logic               clr,
   input  logic [FIELD_W-1:0] field,
   input  logic               base_long,
   input  logic               tick,
   output logic [CW-1:0]      count,
   output logic               expired,
   output logic               run,
   output base_e              base_q
);
   logic hit_zero;

   assign run      = enable && (count != '0);
   assign hit_zero = tick && (count == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= '0;
         base_q <= BASE_SHORT;
      end else if (kick) begin
         count  <= {1'b0, field} + CW'(1);
         base_q <= base_e'(base_long);
      end else if (tick) begin
         count  <= count - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        expired <= 1'b0;
      else if (hit_zero) expired <= 1'b1;
      else if (clr)      expired <= 1'b0;
   end

   // R2
   count_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(1 << FIELD_W));

   // R5
   expire_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(count) == CW'(1) && count == '0) |-> expired);

   // R5
   rest_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && !kick) |=> count == '0);

   // R6
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (expired && !clr) |=> expired);

   // R7
   freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!enable && !kick) |=> $stable(count));
endmodule

// File: rtl/wdt_freq_select.sv
module wdt_freq_select #(
   parameter int unsigned FREQ_W     = 5,
   parameter bit          LATCH_PINS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              override_sw,
   input  logic [FREQ_W-1:0] pins,
   input  logic [FREQ_W-1:0] sw_code,
   output logic [FREQ_W-1:0] pins_q,
   output logic [FREQ_W-1:0] code
);
   generate
      if (LATCH_PINS) begin : g_latched
         logic captured;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               captured <= 1'b0;
               pins_q   <= '0;
            end else if (!captured) begin
               captured <= 1'b1;
               pins_q   <= pins;
            end
         end

         // R8
         pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            captured |=> $stable(pins_q));
      end else begin : g_direct
         assign pins_q = pins;
      end
   endgenerate

   assign code = override_sw ? sw_code : pins_q;
endmodule

// File: rtl/prescaled_wdog.sv
module prescaled_wdog
   import wdt_pkg::*;
#(
   parameter int unsigned FIELD_W    = 5,
   parameter int unsigned FREQ_W     = 5,
   parameter int unsigned TICK_SHORT = 150000,
   parameter int unsigned TICK_LONG  = 2500000,
   parameter bit          LATCH_PINS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               enable,
   input  logic [FIELD_W-1:0] tmo_field,
   input  logic               base_long,
   input  logic               kick,
   input  logic               clr_expired,
   input  logic               freq_override,
   input  logic [FREQ_W-1:0]  freq_pins,
   input  logic [FREQ_W-1:0]  sw_freq,
   output logic [FIELD_W:0]   wd_count,
   output logic               wd_expired,
   output logic [FREQ_W-1:0]  pins_latched,
   output logic [FREQ_W-1:0]  freq_code
);
   generate
      if (FIELD_W < 1 || FIELD_W > 16) begin : g_bad_field
         $error("FIELD_W out of range");
      end
      if (TICK_SHORT < 1 || TICK_LONG < 1) begin : g_bad_tick
         $error("tick periods must be at least one cycle");
      end
      if (FREQ_W < 1) begin : g_bad_freq
         $error("FREQ_W must be positive");
      end
   endgenerate

   logic  tick;
   logic  run;
   base_e base_q;

   wdt_prescaler #(
      .TICK_SHORT(TICK_SHORT),
      .TICK_LONG (TICK_LONG)
   ) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .restart (kick),
      .base_sel(base_q),
      .tick    (tick)
   );

   wdt_countdown #(
      .FIELD_W(FIELD_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (enable),
      .kick     (kick),
      .clr      (clr_expired),
      .field    (tmo_field),
      .base_long(base_long),
      .tick     (tick),
      .count    (wd_count),
      .expired  (wd_expired),
      .run      (run),
      .base_q   (base_q)
   );

   wdt_freq_select #(
      .FREQ_W    (FREQ_W),
      .LATCH_PINS(LATCH_PINS)
   ) u_freq (
      .clk        (clk),
      .rst_n      (rst_n),
      .override_sw(freq_override),
      .pins       (freq_pins),
      .sw_code    (sw_freq),
      .pins_q     (pins_latched),
      .code       (freq_code)
   );

   // R9
   code_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freq_override |-> freq_code == sw_freq);
endmodule

// File: tb/prescaled_wdog_test.sv
module prescaled_wdog_test;
   localparam int CLK_PERIOD = 10;
   localparam int TS = 3;
   localparam int TL = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       enable = 1'b0;
   logic [4:0] tmo_field = '0;
   logic       base_long = 1'b0;
   logic       kick = 1'b0;
   logic       clr_expired = 1'b0;
   logic       freq_override = 1'b0;
   logic [4:0] freq_pins = 5'h15;
   logic [4:0] sw_freq = '0;
   logic [5:0] wd_count;
   logic       wd_expired;
   logic [4:0] pins_latched;
   logic [4:0] freq_code;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   // reference state
   int   m_cnt = 0;
   int   m_pre = 0;
   bit   m_long = 0;
   bit   m_exp = 0;
   bit   m_cap = 0;
   logic [4:0] m_pins = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   prescaled_wdog #(
      .TICK_SHORT(TS),
      .TICK_LONG (TL)
   ) uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .tmo_field(tmo_field),
      .base_long(base_long), .kick(kick), .clr_expired(clr_expired),
      .freq_override(freq_override), .freq_pins(freq_pins), .sw_freq(sw_freq),
      .wd_count(wd_count), .wd_expired(wd_expired),
      .pins_latched(pins_latched), .freq_code(freq_code)
   );

   function automatic int period(input bit lng);
      return lng ? TL : TS;
   endfunction

   function automatic logic [4:0] exp_code(input bit ovr, input logic [4:0] sw, input logic [4:0] pl);
      return ovr ? sw : pl;
   endfunction

   task automatic check(input string req, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, expv, $time);
      end
   endtask

   // advance the model by one edge, then compare at the falling edge
   task automatic cyc();
      bit set_now = 0;
      if (!m_cap) begin m_cap = 1; m_pins = freq_pins; end
      if (kick) begin
         m_cnt = int'(tmo_field) + 1; m_pre = 0; m_long = base_long;
      end else if (enable && m_cnt != 0) begin
         if (m_pre == period(m_long) - 1) begin
            m_pre = 0; m_cnt--;
            if (m_cnt == 0) set_now = 1;
         end else m_pre++;
      end
      if (set_now) m_exp = 1;
      else if (clr_expired) m_exp = 0;
      @(negedge clk);
      check("R3 count", int'(wd_count), m_cnt);
      check("R6 flag", int'(wd_expired), int'(m_exp));
      check("R9 code", int'(freq_code), int'(exp_code(freq_override, sw_freq, m_pins)));
   endtask

   task automatic do_kick(input logic [4:0] f, input bit lng);
      tmo_field = f; base_long = lng; kick = 1'b1;
      cyc();
      kick = 1'b0;
      check("R2 load", int'(wd_count), int'(f) + 1);
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      #(CLK_PERIOD*3 + 1);
      check("R1 count in reset", int'(wd_count), 0);
      check("R1 flag in reset", int'(wd_expired), 0);
      @(negedge clk);
      rst_n = 1'b1;
      cyc();
      check("R1 count after reset", int'(wd_count), 0);
      check("R8 capture", int'(pins_latched), 5'h15);
      freq_pins = 5'h0A;
      cyc();
      check("R8 hold", int'(pins_latched), 5'h15);

      // R5: short expiry and rest at zero
      enable = 1'b1;
      do_kick(5'd1, 1'b0);
      repeat (2*TS) cyc();
      check("R5 expired", int'(wd_expired), 1);
      repeat (10) cyc();
      check("R5 rest at zero", int'(wd_count), 0);

      // R6: clear together with expiry keeps flag set
      clr_expired = 1'b1; cyc(); clr_expired = 1'b0;
      check("R6 cleared", int'(wd_expired), 0);
      do_kick(5'd0, 1'b0);
      repeat (TS-1) cyc();
      clr_expired = 1'b1; cyc(); clr_expired = 1'b0;
      check("R6 set wins", int'(wd_expired), 1);

      // R4: reprogram mid-count, long base keeps its pace
      do_kick(5'd2, 1'b1);
      tmo_field = 5'd31; base_long = 1'b0;
      repeat (TL) cyc();
      check("R4 long pace kept", int'(wd_count), 2);

      // R7: freeze
      enable = 1'b0;
      repeat (20) cyc();
      check("R7 frozen", int'(wd_count), 2);
      do_kick(5'd4, 1'b0);
      repeat (5) cyc();
      check("R7 kick while disabled", int'(wd_count), 5);
      enable = 1'b1;

      // R3: full long countdown of 32 intervals
      clr_expired = 1'b1; cyc(); clr_expired = 1'b0;
      do_kick(5'd31, 1'b1);
      repeat (32*TL - 1) cyc();
      check("R3 not yet expired", int'(wd_expired), 0);
      cyc();
      check("R3 long expiry", int'(wd_expired), 1);

      // random phase
      for (int i = 0; i < 6000; i++) begin
         enable        = ($urandom_range(0, 9) != 0);
         kick          = ($urandom_range(0, 199) == 0);
         clr_expired   = ($urandom_range(0, 59) == 0);
         freq_override = $urandom_range(0, 1);
         sw_freq       = 5'($urandom);
         freq_pins     = 5'($urandom);
         if ($urandom_range(0, 7) == 0) begin
            tmo_field = 5'($urandom);
            base_long = $urandom_range(0, 1);
         end
         cyc();
      end
      kick = 1'b0; clr_expired = 1'b0;
      check("R8 hold after random", int'(pins_latched), 5'h15);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            errors++; checks++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule